// File: doc/BRIEF.md
# Display Panel Command Port

This block is a bus slave that lets a processor talk to one or two external display controllers over a narrow command and pixel link. Software chooses the target panels with chip-select bits. It then writes commands, parameters and packed pixel data, and the block turns each of those writes into 16-bit words on an outgoing valid/ready link. Every word carries a chip mask and a data/command flag. When software reads the data or status port, the block samples the value presented by the selected panel and keeps it in a receive buffer.

The block also tracks a frame transfer. Software loads a pixel countdown and then sets a start bit in the control register. The transfer is busy until the countdown is drained to zero by data and status port accesses. At that point busy drops and a sticky frame-done flag raises the interrupt output. The panel timing, data-cycle and sync-width registers are only stored and read back.

The register map uses word addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | pixel count |
| 2 | system status |
| 3 | command |
| 4 | parameter |
| 5 | data port |
| 6 | status port |
| 7 | interrupt status |
| 8, 9 | configuration 0 and 1 |
| 10 | on/off time 0 |
| 11 | cycle time 0 |
| 12 | on/off time 1 |
| 13 | cycle time 1 |
| 14 to 19 | data-cycle 0 to 5 |
| 20 | vertical sync width |
| 21 | horizontal sync width |
| 22 | receive buffer |

Top module: `panel_cmd_port`

## Requirements
- R1: After reset, the registers read as follows: control reads 2, both configuration registers read 0x00310000, and pixel count, interrupt status, receive buffer, timing, data-cycle and sync registers read 0. Also after reset, chipValid and frameIrq are low and busReady is high.
- R2: Writes keep only the implemented bits:
  - control: bits 3:0
  - configuration: mask 0x003F1FFF
  - on/off time: mask 0x3FFFFFFF
  - cycle time: mask 0x0FFFFFFF
  - data-cycle: mask 0x0F1F0F1F
  - sync widths: mask 0x0000FFFF
  - pixel count: all 32 bits
- R3: Control bit 2 selects chip 0 (chipMask bit 0) and control bit 3 selects chip 1 (chipMask bit 1). With both set, each word carries mask 3. With neither set, command, parameter and data writes put nothing on the link.
- R4: A command write (address 3) sends busWdata[15:0] with chipDcx 0. A parameter write (address 4) sends busWdata[15:0] with chipDcx 1.
- R5: A data write (address 5) sends two words with chipDcx 1: busWdata[15:0] first, then busWdata[31:16].
- R6: While a word is not yet accepted, chipValid stays high with chipWord unchanged, and busReady stays low. busReady returns high in the cycle after the last word of the access is accepted.
- R7: Each data write, data-port read and status-port read decrements the pixel count by one, wrapping from 0 to 0xFFFFFFFF.
- R8: A control write with bit 4 set starts a transfer only if all of these hold; otherwise the start is ignored:
  - the written bit 0 (enable) is 1
  - the written bit 1 (bypass) is 0
  - ifMode is high
  - configuration 0 AND configuration 1 has no bit set among bits 3:2
  - no transfer is already busy
- R9: An accepted start with a nonzero pixel count sets busy. Once busy, a decrement from 1 to 0 clears busy and sets frame-done in the same cycle.
- R10: An accepted start with a pixel count of 0 completes at once: busy stays 0 and frame-done is set.
- R11: Frame-done is bit 0 of interrupt status (address 7) and drives frameIrq. Writing 1 to that bit clears it; writing 0 leaves it unchanged.
- R12: A read of the data port or the status port returns the selected chip's 16-bit chipRdWord value and latches it into the receive buffer (address 22, value in bits 15:0). Bit 16 of the buffer is set to 1 for a data-port read and to 0 for a status-port read. Chip 0 wins when both chips are selected. With no chip selected the read returns 0 and the buffer is unchanged.
- R13: System status (address 2) reads bit 0 = 1 and the busy flag in bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Register word address |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Access accepted this cycle when busSel is high |
| busRdata | output | 32 | Read data for the current access |
| ifMode | input | 1 | Panel interface mode enabled by the display controller |
| chipRdWord | input | 32 | Values presented by chip 1 (bits 31:16) and chip 0 (bits 15:0) |
| chipValid | output | 1 | Outgoing word valid |
| chipReady | input | 1 | Outgoing word accepted |
| chipMask | output | 2 | Target chips of the word |
| chipDcx | output | 1 | 1 = parameter or data, 0 = command |
| chipWord | output | 16 | Outgoing word |
| frameIrq | output | 1 | Frame-done interrupt |

## Verification
Two functions can land in the same cycle: starting a transfer and completing one. When the pixel count is zero at the start, the start is accepted and completed in a single cycle. Likewise, the access that drains the count both decrements it and finishes the frame. The bench provokes the first case by writing a zero count and then a start. It judges the result by checking that busy never shows in system status and that frame-done and frameIrq are set on the next read. For the second case, the bench drains a busy transfer with a status-port read. It then checks that busy has dropped, frame-done is set, and the receive buffer holds the status flag together with the sampled word.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
  localparam logic [ADDR_W-1:0] A_PIXCNT  = 5'd1;
  localparam logic [ADDR_W-1:0] A_SYSSTAT = 5'd2;
  localparam logic [ADDR_W-1:0] A_CMD     = 5'd3;
  localparam logic [ADDR_W-1:0] A_PARAM   = 5'd4;
  localparam logic [ADDR_W-1:0] A_DATA    = 5'd5;
  localparam logic [ADDR_W-1:0] A_STATUS  = 5'd6;
  localparam logic [ADDR_W-1:0] A_IRQ     = 5'd7;
  localparam logic [ADDR_W-1:0] A_CFG0    = 5'd8;
  localparam logic [ADDR_W-1:0] A_TIME0   = 5'd10;
  localparam logic [ADDR_W-1:0] A_DCYC0   = 5'd14;
  localparam logic [ADDR_W-1:0] A_VSYNC   = 5'd20;
  localparam logic [ADDR_W-1:0] A_HSYNC   = 5'd21;
  localparam logic [ADDR_W-1:0] A_RXBUF   = 5'd22;

  localparam int NUM_CFG  = 2;
  localparam int NUM_TIME = 4;
  localparam int NUM_DCYC = 6;

  localparam logic [31:0] CFG_MASK   = 32'h003F_1FFF;
  localparam logic [31:0] CFG_RESET  = 32'h0031_0000;
  localparam logic [31:0] CFG_BLOCK  = 32'h0000_000C;
  localparam logic [31:0] ONOFF_MASK = 32'h3FFF_FFFF;
  localparam logic [31:0] CYCLE_MASK = 32'h0FFF_FFFF;
  localparam logic [31:0] DCYC_MASK  = 32'h0F1F_0F1F;
  localparam logic [31:0] SYNC_MASK  = 32'h0000_FFFF;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_LOW_MORE,
    LK_LOW_LAST,
    LK_HIGH
  } linkState_e;

  typedef struct packed {
    logic regWrite;
    logic decCnt;
    logic latchRx;
    logic rxIsData;
    logic loadLink;
    logic linkFlag;
    logic selHigh;
  } ctrlStrobe_t;

endpackage

// File: rtl/panel_cmd_ctrl.sv
module panel_cmd_ctrl
  import panel_cmd_pkg::*;
#(
  parameter int CHIPS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wEnable,
  input  logic              wBypass,
  input  logic              wStart,
  input  logic              ifMode,
  input  logic [CHIPS-1:0]  csBits,
  input  logic              cntIsZero,
  input  logic              cntIsOne,
  input  logic              cfgConflict,
  input  logic              chipReady,
  output logic              busReady,
  output logic              chipValid,
  output logic              busy,
  output logic              frameDone,
  output ctrlStrobe_t       stb
);

  linkState_e linkState, linkNext;

  logic acc, wrAcc, rdAcc;
  logic isWordWrite, sendWord;
  logic startReq, startOk, decEvent, finish;

  assign busReady = (linkState == LK_IDLE);
  assign chipValid = (linkState != LK_IDLE);

  assign acc = busSel & busReady;
  assign wrAcc = acc & busWr;
  assign rdAcc = acc & ~busWr;

  assign isWordWrite = (busAddr == A_CMD) | (busAddr == A_PARAM) | (busAddr == A_DATA);
  assign sendWord = wrAcc & isWordWrite & (|csBits);

  assign decEvent = (wrAcc & (busAddr == A_DATA)) |
                    (rdAcc & ((busAddr == A_DATA) | (busAddr == A_STATUS)));

  assign startReq = wrAcc & (busAddr == A_CTRL) & wStart;
  assign startOk = startReq & wEnable & ~wBypass & ifMode & ~cfgConflict & ~busy;
  assign finish = busy & decEvent & cntIsOne;

  always_comb begin
    stb.regWrite = wrAcc;
    stb.decCnt   = decEvent;
    stb.latchRx  = rdAcc & ((busAddr == A_DATA) | (busAddr == A_STATUS));
    stb.rxIsData = (busAddr == A_DATA);
    stb.loadLink = sendWord;
    stb.linkFlag = (busAddr != A_CMD);
    stb.selHigh  = (linkState == LK_HIGH);
  end

  always_comb begin
    linkNext = linkState;
    unique case (linkState)
      LK_IDLE:     if (sendWord) linkNext = (busAddr == A_DATA) ? LK_LOW_MORE : LK_LOW_LAST;
      LK_LOW_MORE: if (chipReady) linkNext = LK_HIGH;
      LK_LOW_LAST: if (chipReady) linkNext = LK_IDLE;
      LK_HIGH:     if (chipReady) linkNext = LK_IDLE;
      default:     linkNext = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkState <= LK_IDLE;
      busy      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      linkState <= linkNext;
      if (startOk) busy <= ~cntIsZero;
      else if (finish) busy <= 1'b0;
      if (finish | (startOk & cntIsZero)) frameDone <= 1'b1;
      else if (wrAcc & (busAddr == A_IRQ) & wEnable) frameDone <= 1'b0;
    end
  end

  assert_hold_valid_R6 : assert property (@(posedge clk) disable iff (!rstN)
    chipValid && !chipReady |=> chipValid);

  assert_link_from_write_R4 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipValid) |-> $past(busSel && busWr));

  assert_done_on_finish_R9 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> frameDone);

  assert_start_gate_R8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ifMode && busSel && busWr && !cfgConflict));

endmodule

// File: rtl/panel_cmd_dpath.sv
module panel_cmd_dpath
  import panel_cmd_pkg::*;
#(
  parameter int CHIPS  = 2,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             stb,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [2*WORD_W-1:0]     busWdata,
  input  logic                    busy,
  input  logic                    frameDone,
  input  logic [CHIPS*WORD_W-1:0] chipRdWord,
  output logic [2*WORD_W-1:0]     busRdata,
  output logic [CHIPS-1:0]        csBits,
  output logic                    cntIsZero,
  output logic                    cntIsOne,
  output logic                    cfgConflict,
  output logic [CHIPS-1:0]        chipMask,
  output logic                    chipDcx,
  output logic [WORD_W-1:0]       chipWord
);

  localparam int BUS_W  = 2 * WORD_W;
  localparam int CTRL_W = 2 + CHIPS;
  localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'(2);

  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  pixCnt;
  logic [BUS_W-1:0]  cfgReg  [NUM_CFG];
  logic [BUS_W-1:0]  timeReg [NUM_TIME];
  logic [BUS_W-1:0]  dcycReg [NUM_DCYC];
  logic [BUS_W-1:0]  vsyncReg, hsyncReg;
  logic [WORD_W-1:0] rxWord;
  logic              rxFlag;
  logic [BUS_W-1:0]  linkWord;
  logic              linkFlag;
  logic [CHIPS-1:0]  linkMask;
  logic              selHit;
  logic [WORD_W-1:0] selWord;

  assign csBits      = ctrlReg[CTRL_W-1:2];
  assign cntIsZero   = (pixCnt == '0);
  assign cntIsOne    = (pixCnt == CNT_W'(1));
  assign cfgConflict = |(cfgReg[0] & cfgReg[1] & CFG_BLOCK);

  assign chipMask = linkMask;
  assign chipDcx  = linkFlag;
  assign chipWord = stb.selHigh ? linkWord[BUS_W-1:WORD_W] : linkWord[WORD_W-1:0];

  // Lowest-numbered selected chip wins the read.
  always_comb begin
    selHit  = 1'b0;
    selWord = '0;
    for (int i = CHIPS - 1; i >= 0; i--) begin
      if (csBits[i]) begin
        selHit  = 1'b1;
        selWord = chipRdWord[i*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RESET;
      pixCnt   <= '0;
      vsyncReg <= '0;
      hsyncReg <= '0;
      rxWord   <= '0;
      rxFlag   <= 1'b0;
      linkWord <= '0;
      linkFlag <= 1'b0;
      linkMask <= '0;
      for (int i = 0; i < NUM_CFG; i++) cfgReg[i] <= CFG_RESET;
      for (int i = 0; i < NUM_TIME; i++) timeReg[i] <= '0;
      for (int i = 0; i < NUM_DCYC; i++) dcycReg[i] <= '0;
    end else begin
      if (stb.regWrite) begin
        if (busAddr == A_CTRL) ctrlReg <= busWdata[CTRL_W-1:0];
        if (busAddr == A_VSYNC) vsyncReg <= busWdata & SYNC_MASK;
        if (busAddr == A_HSYNC) hsyncReg <= busWdata & SYNC_MASK;
        for (int i = 0; i < NUM_CFG; i++)
          if (busAddr == A_CFG0 + ADDR_W'(i)) cfgReg[i] <= busWdata & CFG_MASK;
        for (int i = 0; i < NUM_TIME; i++)
          if (busAddr == A_TIME0 + ADDR_W'(i))
            timeReg[i] <= busWdata & (((i % 2) == 0) ? ONOFF_MASK : CYCLE_MASK);
        for (int i = 0; i < NUM_DCYC; i++)
          if (busAddr == A_DCYC0 + ADDR_W'(i)) dcycReg[i] <= busWdata & DCYC_MASK;
      end
      if (stb.regWrite && busAddr == A_PIXCNT) pixCnt <= busWdata[CNT_W-1:0];
      else if (stb.decCnt) pixCnt <= pixCnt - 1'b1;
      if (stb.latchRx && selHit) begin
        rxWord <= selWord;
        rxFlag <= stb.rxIsData;
      end
      if (stb.loadLink) begin
        linkWord <= busWdata;
        linkFlag <= stb.linkFlag;
        linkMask <= csBits;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == A_CTRL) busRdata = BUS_W'(ctrlReg);
    if (busAddr == A_PIXCNT) busRdata = BUS_W'(pixCnt);
    if (busAddr == A_SYSSTAT) busRdata = BUS_W'({busy, 8'h01});
    if (busAddr == A_DATA || busAddr == A_STATUS) busRdata = BUS_W'(selWord);
    if (busAddr == A_IRQ) busRdata = BUS_W'(frameDone);
    if (busAddr == A_VSYNC) busRdata = vsyncReg;
    if (busAddr == A_HSYNC) busRdata = hsyncReg;
    if (busAddr == A_RXBUF) busRdata = BUS_W'({rxFlag, rxWord});
    for (int i = 0; i < NUM_CFG; i++)
      if (busAddr == A_CFG0 + ADDR_W'(i)) busRdata = cfgReg[i];
    for (int i = 0; i < NUM_TIME; i++)
      if (busAddr == A_TIME0 + ADDR_W'(i)) busRdata = timeReg[i];
    for (int i = 0; i < NUM_DCYC; i++)
      if (busAddr == A_DCYC0 + ADDR_W'(i)) busRdata = dcycReg[i];
  end

  assert_rx_latch_R12 : assert property (@(posedge clk) disable iff (!rstN)
    stb.latchRx && csBits[0] |=> rxWord == $past(chipRdWord[WORD_W-1:0]));

  assert_count_drain_R7 : assert property (@(posedge clk) disable iff (!rstN)
    stb.decCnt && cntIsOne && !(stb.regWrite && busAddr == A_PIXCNT) |=> cntIsZero);

endmodule

// File: rtl/panel_cmd_port.sv
module panel_cmd_port
  import panel_cmd_pkg::*;
#(
  parameter int CHIPS  = 2,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busSel,
  input  logic                    busWr,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [2*WORD_W-1:0]     busWdata,
  output logic                    busReady,
  output logic [2*WORD_W-1:0]     busRdata,
  input  logic                    ifMode,
  input  logic [CHIPS*WORD_W-1:0] chipRdWord,
  output logic                    chipValid,
  input  logic                    chipReady,
  output logic [CHIPS-1:0]        chipMask,
  output logic                    chipDcx,
  output logic [WORD_W-1:0]       chipWord,
  output logic                    frameIrq
);

  ctrlStrobe_t      stb;
  logic [CHIPS-1:0] csBits;
  logic             cntIsZero, cntIsOne, cfgConflict;
  logic             busy, frameDone;

  assign frameIrq = frameDone;

  panel_cmd_ctrl #(.CHIPS(CHIPS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .wEnable(busWdata[0]), .wBypass(busWdata[1]), .wStart(busWdata[4]),
    .ifMode(ifMode), .csBits(csBits),
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne), .cfgConflict(cfgConflict),
    .chipReady(chipReady), .busReady(busReady), .chipValid(chipValid),
    .busy(busy), .frameDone(frameDone), .stb(stb)
  );

  panel_cmd_dpath #(.CHIPS(CHIPS), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busAddr(busAddr), .busWdata(busWdata),
    .busy(busy), .frameDone(frameDone), .chipRdWord(chipRdWord),
    .busRdata(busRdata), .csBits(csBits),
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne), .cfgConflict(cfgConflict),
    .chipMask(chipMask), .chipDcx(chipDcx), .chipWord(chipWord)
  );

endmodule

// File: tb/panel_cmd_port_bench.sv
module panel_cmd_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdata;
  logic        ifMode = 1'b0;
  logic [31:0] chipRdWord = '0;
  logic        chipValid, chipReady, chipDcx, frameIrq;
  logic [1:0]  chipMask;
  logic [15:0] chipWord;

  int checks = 0, failures = 0;
  logic readyHold = 1'b0;
  logic [18:0] logEntry [16];
  int logCnt = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  panel_cmd_port u_panel_cmd_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata), .ifMode(ifMode),
    .chipRdWord(chipRdWord), .chipValid(chipValid), .chipReady(chipReady),
    .chipMask(chipMask), .chipDcx(chipDcx), .chipWord(chipWord), .frameIrq(frameIrq)
  );

  // Panel model: ready policy, then record words that will be accepted at the next edge.
  always @(negedge clk) begin
    chipReady = !readyHold;
    if (chipValid && chipReady && logCnt < 16) begin
      logEntry[logCnt] = {chipMask, chipDcx, chipWord};
      logCnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    while (!busReady) @(negedge clk);
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    while (!busReady) @(negedge clk);
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  // {address, write value, expected read-back}
  localparam logic [68:0] VEC [10] = '{
    {5'd8,  32'hFFFF_FFFF, 32'h003F_1FFF},
    {5'd9,  32'h1234_5678, 32'h0034_1678},
    {5'd10, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
    {5'd13, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
    {5'd14, 32'hFFFF_FFFF, 32'h0F1F_0F1F},
    {5'd19, 32'hA5A5_A5A5, 32'h0505_0505},
    {5'd20, 32'hFFFF_FFFF, 32'h0000_FFFF},
    {5'd21, 32'h0001_2345, 32'h0000_2345},
    {5'd0,  32'hFFFF_FFEF, 32'h0000_000F},
    {5'd1,  32'hDEAD_BEEF, 32'hDEAD_BEEF}
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, R13 status word
    chk("R1 busReady", 32'(busReady), 32'd1);
    chk("R1 chipValid", 32'(chipValid), 32'd0);
    chk("R1 frameIrq", 32'(frameIrq), 32'd0);
    busRead(5'd0, rd);  chk("R1 control", rd, 32'h2);
    busRead(5'd8, rd);  chk("R1 cfg0", rd, 32'h0031_0000);
    busRead(5'd9, rd);  chk("R1 cfg1", rd, 32'h0031_0000);
    busRead(5'd1, rd);  chk("R1 pixcnt", rd, 32'h0);
    busRead(5'd12, rd); chk("R1 time", rd, 32'h0);
    busRead(5'd22, rd); chk("R1 rxbuf", rd, 32'h0);
    busRead(5'd2, rd);  chk("R13 sysstat idle", rd, 32'h1);

    // R2 masking table
    for (int i = 0; i < 10; i++) begin
      busWrite(VEC[i][68:64], VEC[i][63:32]);
      busRead(VEC[i][68:64], rd);
      chk("R2 mask", rd, VEC[i][31:0]);
    end

    // R8 blocked by configuration overlap (cfg0 & cfg1 has bit 3)
    ifMode = 1'b1;
    busWrite(5'd1, 32'd3);
    busWrite(5'd0, 32'h15);
    busRead(5'd2, rd); chk("R8 cfg conflict blocks", rd, 32'h1);
    busWrite(5'd9, 32'h0);
    busWrite(5'd0, 32'h15);
    busRead(5'd2, rd); chk("R9 R13 busy set", rd, 32'h101);
    busWrite(5'd0, 32'h15);
    busRead(5'd1, rd); chk("R8 start while busy ignored", rd, 32'd3);

    // R4 command to chip 0
    busWrite(5'd3, 32'hABCD_1234);
    repeat (2) @(negedge clk);
    chk("R4 cmd count", 32'(logCnt), 32'd1);
    chk("R4 R3 cmd word", 32'(logEntry[0]), 32'({2'b01, 1'b0, 16'h1234}));

    // R3 both chips, parameter
    busWrite(5'd0, 32'h0D);
    busWrite(5'd4, 32'h0000_5678);
    repeat (2) @(negedge clk);
    chk("R3 R4 param word", 32'(logEntry[1]), 32'({2'b11, 1'b1, 16'h5678}));

    // R5 R6 data write against a stalled panel
    readyHold = 1'b1;
    busWrite(5'd5, 32'hCAFE_BEEF);
    @(negedge clk);
    chk("R6 stall busReady", 32'(busReady), 32'd0);
    chk("R6 valid held", 32'(chipValid), 32'd1);
    repeat (3) @(negedge clk);
    chk("R6 word stable", 32'(chipWord), 32'hBEEF);
    #1 readyHold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 ready back", 32'(busReady), 32'd1);
    chk("R5 word count", 32'(logCnt), 32'd4);
    chk("R5 low half", 32'(logEntry[2]), 32'({2'b11, 1'b1, 16'hBEEF}));
    chk("R5 high half", 32'(logEntry[3]), 32'({2'b11, 1'b1, 16'hCAFE}));
    busRead(5'd1, rd); chk("R7 data write decrements", rd, 32'd2);

    // R12 read priority, then drain to zero with a status read (R9 R11)
    chipRdWord = 32'h2222_1111;
    busRead(5'd5, rd); chk("R12 chip0 priority", rd, 32'h1111);
    busRead(5'd22, rd); chk("R12 rx data flag", rd, 32'h0001_1111);
    busWrite(5'd0, 32'h09);
    busRead(5'd6, rd); chk("R12 status read chip1", rd, 32'h2222);
    busRead(5'd22, rd); chk("R12 rx status flag", rd, 32'h0000_2222);
    busRead(5'd2, rd); chk("R9 busy cleared", rd, 32'h1);
    busRead(5'd7, rd); chk("R11 frame done", rd, 32'h1);
    chk("R11 irq out", 32'(frameIrq), 32'd1);
    busWrite(5'd7, 32'h0);
    busRead(5'd7, rd); chk("R11 write 0 keeps", rd, 32'h1);
    busWrite(5'd7, 32'h1);
    busRead(5'd7, rd); chk("R11 clear", rd, 32'h0);

    // R3 no chip selected: nothing sent, R12 buffer unchanged, R7 wrap
    busWrite(5'd0, 32'h01);
    busWrite(5'd3, 32'h0000_7777);
    repeat (2) @(negedge clk);
    chk("R3 no chip no word", 32'(logCnt), 32'd4);
    busRead(5'd5, rd); chk("R12 none selected", rd, 32'h0);
    busRead(5'd22, rd); chk("R12 rx unchanged", rd, 32'h0000_2222);
    busRead(5'd1, rd); chk("R7 wrap", rd, 32'hFFFF_FFFF);

    // R10 zero-count start completes at once
    busWrite(5'd1, 32'd0);
    busWrite(5'd0, 32'h15);
    busRead(5'd2, rd); chk("R10 never busy", rd, 32'h1);
    busRead(5'd7, rd); chk("R10 frame done", rd, 32'h1);
    busWrite(5'd7, 32'h1);

    // R8 remaining gates
    busWrite(5'd1, 32'd5);
    ifMode = 1'b0;
    busWrite(5'd0, 32'h15);
    busRead(5'd2, rd); chk("R8 ifMode low", rd, 32'h1);
    ifMode = 1'b1;
    busWrite(5'd0, 32'h17);
    busRead(5'd2, rd); chk("R8 bypass", rd, 32'h1);
    busWrite(5'd0, 32'h14);
    busRead(5'd2, rd); chk("R8 disabled", rd, 32'h1);
    busRead(5'd7, rd); chk("R8 no frame done", rd, 32'h0);
    busWrite(5'd5, 32'h0);
    busRead(5'd1, rd); chk("R7 idle decrement", rd, 32'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule